// File: doc/BRIEF.md
# Auto-Incrementing Work-RAM Access Port

This block gives a host a narrow, register-mapped way into a 128 KiB work RAM. The host loads a 17-bit pointer one piece at a time, as a low byte, a middle byte and a single top bit, through three address registers. It then moves data through one data register. Every data access, whether a read or a write, uses the current pointer and then advances it by one. A host can therefore stream a block of bytes in or out of the RAM without reloading the address.

The pointer is combined with a fixed base in the 24-bit system address space (bank 0x7E upward) and sent to the RAM on a simple request port. The request is asserted in the same cycle as the host strobe. A synchronous RAM answers a read one cycle later, and the block hands that byte back to the host with a valid flag.

Top module: `wram_window`

## Requirements
- R1: While reset is asserted and immediately after reset, the pointer is zero, `hst_rvalid` is 0, `hst_rdata` is 0 and no RAM request is issued. The first data access after reset therefore targets 0x7E0000.
- R2: Register offsets are fixed as follows: offset 0 is the data register, offset 1 loads pointer bits 7:0, offset 2 loads pointer bits 15:8 and offset 3 loads pointer bit 16. Loading one of these fields leaves every other pointer bit unchanged.
- R3: A write to offset 3 takes only bit 0 of `hst_wdata` as pointer bit 16 and ignores bits 7:1.
- R4: During a data access, `ram_addr` equals 0x7E0000 OR'ed with the zero-extended pointer. For a write, `ram_we` is 1 and `ram_wdata` equals `hst_wdata`. For a read, `ram_we` is 0.
- R5: Every data-register read strobe and every data-register write strobe advances the pointer by exactly one. Back-to-back strobes reach consecutive addresses.
- R6: The pointer wraps from 0x1FFFF to 0x00000 when it advances.
- R7: A data-register read presents `hst_rvalid`=1 and `hst_rdata` equal to the RAM byte in the cycle after the strobe. `hst_rdata` is 0 whenever `hst_rvalid` is 0.
- R8: When read and write strobes arrive together at offset 0, only the write is performed. The pointer advances once and no read data is returned.
- R9: A read strobe at an address-register offset (1 to 3) has no effect. It issues no RAM request, returns no data and leaves the pointer unchanged.
- R10: `ram_req` is asserted only in a cycle with a read or write strobe at offset 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hst_addr | input | 2 | Register offset |
| hst_wr | input | 1 | Host write strobe |
| hst_rd | input | 1 | Host read strobe |
| hst_wdata | input | 8 | Host write data |
| hst_rdata | output | 8 | Read data, zero when not valid |
| hst_rvalid | output | 1 | Read data valid, one cycle after the strobe |
| ram_req | output | 1 | RAM access request |
| ram_we | output | 1 | RAM write enable |
| ram_addr | output | 24 | RAM byte address in the system map |
| ram_wdata | output | 8 | RAM write data |
| ram_rdata | input | 8 | RAM read data, one cycle after request |

## Verification
The RAM request, address, write enable and write data are due in the same cycle as the host strobe, so they are compared at the falling edge inside that strobe cycle. Read data and its valid flag are due exactly one rising edge after the strobe. The reference model carries a one-cycle pending record and compares at the following falling edge. Pointer changes appear only through the address of the next access, and each directed check samples that later strobe cycle.

// File: rtl/wram_pkg.sv
package wram_pkg;

  typedef enum logic [1:0] {
    OFS_DATA = 2'd0,
    OFS_LO   = 2'd1,
    OFS_MID  = 2'd2,
    OFS_TOP  = 2'd3
  } wram_ofs_e;

  // Advance a pointer of width w by one, wrapping to zero.
  function automatic logic [31:0] wrap_inc(input logic [31:0] v, input int w);
    logic [31:0] mask;
    mask = (32'd1 << w) - 32'd1;
    return (v + 32'd1) & mask;
  endfunction

  // Place a pointer into the system address space above a fixed base.
  function automatic logic [31:0] place_addr(input logic [31:0] base, input logic [31:0] ptr);
    return base | ptr;
  endfunction

  // Merge loaded lane bits into a pointer.
  function automatic logic [31:0] merge_bits(input logic [31:0] cur, input logic [31:0] val,
                                             input logic [31:0] mask);
    return (cur & ~mask) | (val & mask);
  endfunction

endpackage

// File: rtl/wram_decode.sv
module wram_decode #(
  parameter int REG_AW    = 2,
  parameter int NUM_LANES = 3
) (
  input  logic [REG_AW-1:0]    hst_addr,
  input  logic                 hst_wr,
  input  logic                 hst_rd,
  output logic                 ev_wr,
  output logic                 ev_rd,
  output logic                 ev_access,
  output logic [NUM_LANES-1:0] lane_ld
);
  logic is_data;

  assign is_data   = (hst_addr == REG_AW'(0));
  assign ev_wr     = hst_wr && is_data;
  assign ev_rd     = hst_rd && !hst_wr && is_data;
  assign ev_access = ev_wr || ev_rd;

  for (genvar i = 0; i < NUM_LANES; i++) begin : g_ld
    assign lane_ld[i] = hst_wr && (hst_addr == REG_AW'(i + 1));
  end
endmodule

// File: rtl/wram_ptr.sv
module wram_ptr
  import wram_pkg::*;
#(
  parameter int PTR_W     = 17,
  parameter int LANE_W    = 8,
  parameter int NUM_LANES = (PTR_W + LANE_W - 1) / LANE_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LANES-1:0] lane_ld,
  input  logic                 inc,
  input  logic [LANE_W-1:0]    wdata,
  output logic [PTR_W-1:0]     ptr_q
);
  logic [PTR_W-1:0] ld_mask;
  logic [PTR_W-1:0] ld_val;
  logic [PTR_W-1:0] ptr_d;

  for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
    localparam int LO = i * LANE_W;
    localparam int HI = ((LO + LANE_W) > PTR_W) ? PTR_W - 1 : LO + LANE_W - 1;
    assign ld_mask[HI:LO] = {(HI - LO + 1){lane_ld[i]}};
    assign ld_val[HI:LO]  = wdata[HI-LO:0];
  end

  always_comb begin
    if (inc)
      ptr_d = PTR_W'(wrap_inc(32'(ptr_q), PTR_W));
    else
      ptr_d = PTR_W'(merge_bits(32'(ptr_q), 32'(ld_val), 32'(ld_mask)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= ptr_d;
  end
endmodule

// File: rtl/wram_rdret.sv
module wram_rdret #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_rd,
  input  logic [DATA_W-1:0] ram_rdata,
  output logic              hst_rvalid,
  output logic [DATA_W-1:0] hst_rdata
);
  logic rd_pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_pend <= 1'b0;
    else        rd_pend <= ev_rd;
  end

  assign hst_rvalid = rd_pend;
  assign hst_rdata  = rd_pend ? ram_rdata : '0;
endmodule

// File: rtl/wram_window.sv
module wram_window
  import wram_pkg::*;
#(
  parameter int              PTR_W  = 17,
  parameter int              DATA_W = 8,
  parameter int              ADDR_W = 24,
  parameter logic [ADDR_W-1:0] BASE = 24'h7E0000,
  localparam int             NUM_LANES = (PTR_W + DATA_W - 1) / DATA_W,
  localparam int             REG_AW    = $clog2(NUM_LANES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [REG_AW-1:0] hst_addr,
  input  logic              hst_wr,
  input  logic              hst_rd,
  input  logic [DATA_W-1:0] hst_wdata,
  output logic [DATA_W-1:0] hst_rdata,
  output logic              hst_rvalid,
  output logic              ram_req,
  output logic              ram_we,
  output logic [ADDR_W-1:0] ram_addr,
  output logic [DATA_W-1:0] ram_wdata,
  input  logic [DATA_W-1:0] ram_rdata
);
  // Named internal events, observed by the checker.
  logic                 ev_wr;
  logic                 ev_rd;
  logic                 ev_access;
  logic [NUM_LANES-1:0] lane_ld;
  logic [PTR_W-1:0]     ptr_q;

  wram_decode #(.REG_AW(REG_AW), .NUM_LANES(NUM_LANES)) u_dec (
    .hst_addr (hst_addr),
    .hst_wr   (hst_wr),
    .hst_rd   (hst_rd),
    .ev_wr    (ev_wr),
    .ev_rd    (ev_rd),
    .ev_access(ev_access),
    .lane_ld  (lane_ld)
  );

  wram_ptr #(.PTR_W(PTR_W), .LANE_W(DATA_W), .NUM_LANES(NUM_LANES)) u_ptr (
    .clk    (clk),
    .rst_n  (rst_n),
    .lane_ld(lane_ld),
    .inc    (ev_access),
    .wdata  (hst_wdata),
    .ptr_q  (ptr_q)
  );

  wram_rdret #(.DATA_W(DATA_W)) u_ret (
    .clk       (clk),
    .rst_n     (rst_n),
    .ev_rd     (ev_rd),
    .ram_rdata (ram_rdata),
    .hst_rvalid(hst_rvalid),
    .hst_rdata (hst_rdata)
  );

  assign ram_req   = ev_access;
  assign ram_we    = ev_wr;
  assign ram_addr  = ADDR_W'(place_addr(32'(BASE), 32'(ptr_q)));
  assign ram_wdata = hst_wdata;
endmodule

// File: rtl/wram_window_chk.sv
module wram_window_chk #(
  parameter int                PTR_W     = 17,
  parameter int                DATA_W    = 8,
  parameter int                ADDR_W    = 24,
  parameter logic [ADDR_W-1:0] BASE      = 24'h7E0000,
  parameter int                NUM_LANES = 3,
  parameter int                REG_AW    = 2
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [REG_AW-1:0]    hst_addr,
  input logic                 hst_wr,
  input logic                 hst_rd,
  input logic [DATA_W-1:0]    hst_wdata,
  input logic [DATA_W-1:0]    hst_rdata,
  input logic                 hst_rvalid,
  input logic                 ram_req,
  input logic [ADDR_W-1:0]    ram_addr,
  input logic [PTR_W-1:0]     ptr_q,
  input logic                 ev_access,
  input logic                 ev_rd,
  input logic [NUM_LANES-1:0] lane_ld
);
  localparam int TOP_LO = (NUM_LANES - 1) * DATA_W;

  // R5
  step_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_access |=> (PTR_W'(ptr_q - $past(ptr_q)) == PTR_W'(1)));

  // R2
  lo_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lane_ld[0] |=> (ptr_q[PTR_W-1:DATA_W] == $past(ptr_q[PTR_W-1:DATA_W]))
                   && (ptr_q[DATA_W-1:0] == $past(hst_wdata)));

  // R3
  top_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lane_ld[NUM_LANES-1] |=> (ptr_q[TOP_LO-1:0] == $past(ptr_q[TOP_LO-1:0]))
                             && (ptr_q[PTR_W-1:TOP_LO] == $past(hst_wdata[PTR_W-TOP_LO-1:0])));

  // R10
  req_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ram_req |-> ((hst_addr == REG_AW'(0)) && (hst_rd || hst_wr)));

  // R4
  base_region_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ram_req |-> (ram_addr[ADDR_W-1:PTR_W] == BASE[ADDR_W-1:PTR_W]));

  // R7
  rvalid_due_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_rd |=> hst_rvalid);

  // R7
  rdata_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hst_rvalid |-> (hst_rdata == '0));

  // R8
  write_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hst_wr && hst_rd && (hst_addr == REG_AW'(0))) |=> !hst_rvalid);

  // R9
  ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ev_access && (lane_ld == '0)) |=> $stable(ptr_q));
endmodule

bind wram_window wram_window_chk #(
  .PTR_W(PTR_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .BASE(BASE),
  .NUM_LANES(NUM_LANES), .REG_AW(REG_AW)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .hst_addr  (hst_addr),
  .hst_wr    (hst_wr),
  .hst_rd    (hst_rd),
  .hst_wdata (hst_wdata),
  .hst_rdata (hst_rdata),
  .hst_rvalid(hst_rvalid),
  .ram_req   (ram_req),
  .ram_addr  (ram_addr),
  .ptr_q     (ptr_q),
  .ev_access (ev_access),
  .ev_rd     (ev_rd),
  .lane_ld   (lane_ld)
);

// File: tb/wram_window_tb.sv
module wram_window_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  hst_addr = '0;
  logic        hst_wr = 1'b0;
  logic        hst_rd = 1'b0;
  logic [7:0]  hst_wdata = '0;
  logic [7:0]  hst_rdata;
  logic        hst_rvalid;
  logic        ram_req;
  logic        ram_we;
  logic [23:0] ram_addr;
  logic [7:0]  ram_wdata;
  logic [7:0]  ram_rdata = '0;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2 clk = ~clk;  // 250 MHz

  wram_window u_dut (
    .clk(clk), .rst_n(rst_n), .hst_addr(hst_addr), .hst_wr(hst_wr), .hst_rd(hst_rd),
    .hst_wdata(hst_wdata), .hst_rdata(hst_rdata), .hst_rvalid(hst_rvalid),
    .ram_req(ram_req), .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata),
    .ram_rdata(ram_rdata)
  );

  function automatic logic [7:0] fill(input int a);
    return 8'(a * 7 + 8'h3C);
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // Synchronous RAM model: request captured at the falling edge, acted on at the rising edge.
  byte unsigned ram_mem[int];
  logic        c_req, c_we;
  logic [23:0] c_addr;
  logic [7:0]  c_wd;
  always @(negedge clk) begin
    c_req = ram_req; c_we = ram_we; c_addr = ram_addr; c_wd = ram_wdata;
  end
  always @(posedge clk) begin
    if (c_req && c_we) ram_mem[int'(c_addr)] = c_wd;
    else if (c_req) ram_rdata <= ram_mem.exists(int'(c_addr)) ? ram_mem[int'(c_addr)] : fill(int'(c_addr));
  end

  // Behavioural reference model, compared at every falling edge.
  byte unsigned ref_mem[int];
  int  m_ptr = 0;
  bit  m_pend = 0;
  int  m_data = 0;
  always @(negedge clk) begin
    if (!rst_n) begin
      m_ptr = 0; m_pend = 0;
      chk(hst_rvalid == 1'b0, "R1", "rvalid in reset", hst_rvalid, 0);
      chk(ram_req == 1'b0, "R1", "ram_req in reset", ram_req, 0);
      chk(hst_rdata == 8'h00, "R1", "rdata in reset", hst_rdata, 0);
    end else if (!done) begin
      bit dsel, e_req, e_we;
      int full;
      dsel  = (hst_addr == 2'd0);
      e_we  = hst_wr && dsel;
      e_req = (hst_wr || hst_rd) && dsel;
      full  = 32'h7E0000 | m_ptr;
      chk(ram_req == e_req, "R10", "ram_req", ram_req, e_req);
      if (e_req) begin
        chk(ram_addr == 24'(full), "R4", "ram_addr", ram_addr, full);
        chk(ram_we == e_we, "R4", "ram_we", ram_we, e_we);
        if (e_we) chk(ram_wdata == hst_wdata, "R4", "ram_wdata", ram_wdata, hst_wdata);
      end
      chk(hst_rvalid == m_pend, "R7", "rvalid", hst_rvalid, m_pend);
      chk(hst_rdata == (m_pend ? 8'(m_data) : 8'h00), "R7", "rdata", hst_rdata,
          m_pend ? m_data : 0);
      m_pend = e_req && !e_we;
      if (e_we) ref_mem[full] = hst_wdata;
      else if (e_req) m_data = ref_mem.exists(full) ? ref_mem[full] : fill(full);
      if (e_req) m_ptr = (m_ptr + 1) % 32'h20000;
      else if (hst_wr) begin
        case (hst_addr)
          2'd1: m_ptr = (m_ptr & 32'h1FF00) | hst_wdata;
          2'd2: m_ptr = (m_ptr & 32'h100FF) | (int'(hst_wdata) << 8);
          default: m_ptr = (m_ptr & 32'h0FFFF) | (int'(hst_wdata[0]) << 16);
        endcase
      end
    end
  end

  // One bus cycle: drive after the rising edge, return at the falling edge.
  task automatic step(input bit rd, input bit wr, input logic [1:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    hst_rd = rd; hst_wr = wr; hst_addr = a; hst_wdata = d;
    @(negedge clk);
  endtask

  task automatic load_ptr(input int p);
    step(0, 1, 2'd1, 8'(p));
    step(0, 1, 2'd2, 8'(p >> 8));
    step(0, 1, 2'd3, 8'(p >> 16));
  endtask

  task automatic report;
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected finished");
    report();
  end

  initial begin
    logic [7:0] pat [4];
    pat[0] = 8'hAA; pat[1] = 8'hBB; pat[2] = 8'hCC; pat[3] = 8'hDD;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1: first access after reset hits the base
    step(1, 0, 2'd0, 8'h00);
    chk(ram_addr == 24'h7E0000, "R1", "first addr", ram_addr, 24'h7E0000);
    // R5: a read advances the pointer
    step(1, 0, 2'd0, 8'h00);
    chk(ram_addr == 24'h7E0001, "R5", "second addr", ram_addr, 24'h7E0001);

    // R3: top register ignores bits 7:1
    step(0, 1, 2'd1, 8'h34);
    step(0, 1, 2'd2, 8'h12);
    step(0, 1, 2'd3, 8'hFE);
    step(1, 0, 2'd0, 8'h00);
    chk(ram_addr == 24'h7E1234, "R3", "top bit0=0", ram_addr, 24'h7E1234);
    step(0, 1, 2'd3, 8'h01);
    step(0, 1, 2'd0, 8'h5A);
    chk(ram_addr == 24'h7F1235, "R3", "top bit set", ram_addr, 24'h7F1235);
    chk(ram_we == 1'b1, "R4", "write enable", ram_we, 1);

    // R2: middle byte load keeps low byte and top bit
    step(0, 1, 2'd2, 8'h80);
    step(1, 0, 2'd0, 8'h00);
    chk(ram_addr == 24'h7F8036, "R2", "mid only", ram_addr, 24'h7F8036);

    // R9: read strobes at address offsets have no effect
    step(1, 0, 2'd1, 8'h00);
    chk(ram_req == 1'b0, "R9", "no req on offset 1", ram_req, 0);
    step(1, 0, 2'd3, 8'h00);
    step(0, 0, 2'd0, 8'h00);
    chk(hst_rvalid == 1'b0, "R9", "no data on offset 3", hst_rvalid, 0);
    step(0, 1, 2'd0, 8'h11);
    chk(ram_addr == 24'h7F8037, "R9", "pointer held", ram_addr, 24'h7F8037);

    // R8: simultaneous strobes act as a write only
    step(1, 1, 2'd0, 8'h22);
    chk(ram_we == 1'b1, "R8", "write taken", ram_we, 1);
    chk(ram_addr == 24'h7F8038, "R8", "addr", ram_addr, 24'h7F8038);
    step(0, 0, 2'd0, 8'h00);
    chk(hst_rvalid == 1'b0, "R8", "no read data", hst_rvalid, 0);

    // R6: wrap from the last location to zero
    load_ptr(32'h1FFFF);
    step(0, 1, 2'd0, 8'h77);
    chk(ram_addr == 24'h7FFFFF, "R6", "last addr", ram_addr, 24'h7FFFFF);
    step(1, 0, 2'd0, 8'h00);
    chk(ram_addr == 24'h7E0000, "R6", "wrapped", ram_addr, 24'h7E0000);

    // R7: streamed write then back-to-back read-back
    load_ptr(32'h00100);
    for (int k = 0; k < 4; k++) step(0, 1, 2'd0, pat[k]);
    load_ptr(32'h00100);
    for (int k = 0; k < 4; k++) begin
      step(1, 0, 2'd0, 8'h00);
      if (k > 0) chk(hst_rdata == pat[k-1], "R7", "stream data", hst_rdata, pat[k-1]);
    end
    step(0, 0, 2'd0, 8'h00);
    chk(hst_rdata == pat[3], "R7", "last data", hst_rdata, pat[3]);
    chk(hst_rvalid == 1'b1, "R7", "last valid", hst_rvalid, 1);

    // Mixed traffic under the reference model (R5, R7, R10)
    for (int n = 0; n < 400; n++) begin
      int r;
      r = int'($urandom_range(0, 9));
      if (r < 4) step(1, 0, 2'd0, 8'h00);
      else if (r < 7) step(0, 1, 2'd0, 8'($urandom));
      else if (r < 9) step(($urandom & 1) == 1, 1, 2'($urandom_range(1, 3)), 8'($urandom));
      else step(0, 0, 2'($urandom), 8'h00);
    end
    step(0, 0, 2'd0, 8'h00);
    step(0, 0, 2'd0, 8'h00);
    report();
  end
endmodule